// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the address sequence for a four-beat burst. A load strobe captures a full start address. Each later advance strobe steps the two low-order bits to the next beat. The upper bits stay as they were captured for the whole burst.

A run-time mode input picks the beat ordering. In XOR ordering, the low bits are the start bits XORed with a beat counter. In wrap ordering, the low bits count up by one modulo four inside the aligned group of four. A clock enable freezes all state when it is low.

The sequencer is meant to sit between a command decoder and a memory array's address port. It has no further logic of its own.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addr_o is all zeros and the beat counter is zero.
- R2: With cen_i high and load_i high, addr_o takes addr_i on the next clock edge and the beat counter returns to zero. Load wins when load_i and adv_i are both high.
- R3: With mode_i = 1 (XOR ordering), each advance sets the low two bits of addr_o to start[1:0] XOR the beat count. Starting at 01 the beats are 01, 00, 11, 10. Starting at 11 the beats are 11, 10, 01, 00.
- R4: With mode_i = 0 (wrap ordering), each advance sets the low two bits to start[1:0] plus the beat count, modulo 4. Starting at 10 the beats are 10, 11, 00, 01.
- R5: An advance after the fourth beat wraps back to the burst's start bits. It never carries into bit 2 or above.
- R6: addr_o bits above bit 1 change only on a load.
- R7: With cen_i low, addr_o and the beat counter hold, whatever load_i, adv_i and addr_i do.
- R8: With cen_i high and both load_i and adv_i low, addr_o holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_i | input | 1 | Clock enable; low freezes all state |
| mode_i | input | 1 | 1 selects XOR ordering, 0 selects wrap ordering |
| load_i | input | 1 | Capture addr_i as the burst start |
| adv_i | input | 1 | Step to the next beat |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current burst address |

## Verification
Load and advance can both be high in the same cycle. The bench drives both strobes together in the middle of a burst. It expects addr_o to equal the new start address and the following advance to give beat one of the new burst; it does not expect a step from the old burst. A second collision is a strobe pair arriving while clock enable is low. The bench expects no change at all there, and a check of the next advance confirms that the beat count also held.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {ORD_WRAP = 1'b0, ORD_XOR = 1'b1} ord_e;
  localparam int unsigned BEAT_W = 2;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_i,
  input  logic              load_i,
  input  logic              adv_i,
  output logic [BEAT_W-1:0] beat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                beat_o <= '0;
    else if (cen_i && load_i)   beat_o <= '0;
    else if (cen_i && adv_i)    beat_o <= beat_o + 1'b1; // wraps mod 4
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_i |=> $stable(beat_o));
  p_load_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && load_i) |=> beat_o == '0);
endmodule

// File: rtl/burst_ord_map.sv
module burst_ord_map
  import burst_seq_pkg::*;
(
  input  logic              mode_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] low_o
);
  always_comb begin
    if (ord_e'(mode_i) == ORD_XOR) low_o = start_i ^ beat_i;
    else                           low_o = start_i + beat_i;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_i,
  input  logic              mode_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int unsigned HI_W = ADDR_W - BEAT_W;

  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] start_q, low_q, beat_q, beat_nx, low_nx;

  burst_beat_ctr i_ctr (
    .clk_i, .rst_ni, .cen_i, .load_i, .adv_i, .beat_o(beat_q)
  );

  assign beat_nx = beat_q + 1'b1;

  burst_ord_map i_map (
    .mode_i, .start_i(start_q), .beat_i(beat_nx), .low_o(low_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0; start_q <= '0; low_q <= '0;
    end else if (cen_i && load_i) begin
      hi_q    <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
      low_q   <= addr_i[BEAT_W-1:0];
    end else if (cen_i && adv_i) begin
      low_q <= low_nx;
    end
  end

  assign addr_o = {hi_q, low_q};

  p_hi_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cen_i && load_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_i |=> $stable(addr_o));
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && !load_i && !adv_i) |=> $stable(addr_o));
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && load_i) |=> addr_o == $past(addr_i));
  p_xor_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_i && !load_i && adv_i && mode_i) |=>
      $countones(addr_o[BEAT_W-1:0] ^ $past(addr_o[BEAT_W-1:0])) >= 1);
endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;
  localparam int AW = 20;
  logic clk = 0, rst_n = 0, cen = 0, mode = 1, ld = 0, adv = 0;
  logic [AW-1:0] ain = '0, aout;
  int checks = 0, errors = 0;

  always #4 clk = ~clk; // 125 MHz

  burst_addr_seq #(.ADDR_W(AW)) i_burst_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .cen_i(cen), .mode_i(mode),
    .load_i(ld), .adv_i(adv), .addr_i(ain), .addr_o(aout));

  // vector: mode, start, then expected low bits of beats 1..4 and the wrap beat
  typedef struct packed {
    logic m; logic [1:0] s; logic [1:0] b1, b2, b3, b4, b5;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b1, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
    '{1'b1, 2'd1, 2'd1, 2'd0, 2'd3, 2'd2, 2'd1},
    '{1'b1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
    '{1'b1, 2'd3, 2'd3, 2'd2, 2'd1, 2'd0, 2'd3},
    '{1'b0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0},
    '{1'b0, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1},
    '{1'b0, 2'd2, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2},
    '{1'b0, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3}
  };

  task automatic chk(input string req, input logic [AW-1:0] exp);
    checks++;
    if (aout !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, aout, exp);
    end
  endtask

  task automatic step(input logic c, input logic l, input logic a,
                      input logic [AW-1:0] ad);
    cen = c; ld = l; adv = a; ain = ad;
    @(posedge clk); #2;
    cen = 1; ld = 0; adv = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] hi;
    #1; chk("R1", '0);
    repeat (2) @(posedge clk);
    #2 rst_n = 1;
    chk("R1", '0);

    for (int i = 0; i < 8; i++) begin
      hi = AW'(32'h5A5A4 + i * 8);
      mode = VECS[i].m;
      step(1, 1, 0, hi | AW'(VECS[i].s));
      chk("R2", hi | AW'(VECS[i].b1));
      step(1, 0, 1, '1);
      chk(VECS[i].m ? "R3" : "R4", hi | AW'(VECS[i].b2));
      step(1, 0, 1, '1);
      chk(VECS[i].m ? "R3" : "R4", hi | AW'(VECS[i].b3));
      step(1, 0, 1, '1);
      chk(VECS[i].m ? "R3 R6" : "R4 R6", hi | AW'(VECS[i].b4));
      step(1, 0, 1, '1);
      chk("R5", hi | AW'(VECS[i].b5));
    end

    // R7: enable low freezes address and beat count
    mode = 1;
    step(1, 1, 0, 20'hABCD1);
    step(1, 0, 1, '0);
    chk("R3", 20'hABCD0);
    step(0, 1, 1, 20'h12345);
    chk("R7", 20'hABCD0);
    step(0, 0, 1, '0);
    chk("R7", 20'hABCD0);
    step(1, 0, 1, '0);
    chk("R7", 20'hABCD3);

    // R8: idle holds
    step(1, 0, 0, 20'hFFFFF);
    chk("R8", 20'hABCD3);

    // R2: load wins over advance mid-burst, beat count restarts
    mode = 0;
    step(1, 1, 1, 20'h00F32);
    chk("R2", 20'h00F32);
    step(1, 0, 1, '0);
    chk("R2", 20'h00F33);

    // R4: mode switched in the middle of a burst uses the new rule from the held count
    mode = 1;
    step(1, 0, 1, '0);
    chk("R3", 20'h00F30);

    // R1: asynchronous reset mid-run
    #1 rst_n = 0; #1;
    chk("R1", '0);
    rst_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule